// File: doc/BRIEF.md
# Debug UART Load Port

This block sits on the load path of a 64-bit big-endian core. Every load request carries an address and a size in bytes. Two fixed addresses belong to a debug UART and are answered locally. Every other address is passed to a little-endian memory, and the bytes that memory returns are put back into big-endian order before they reach the core.

The data address returns the last received byte together with a flag that says whether that byte is new. Reading it clears the flag. The status address returns a fixed constant, which tells software that transmit space is always available.

Every accepted request is answered exactly one cycle later, so the core can issue one request per cycle. The receive side is a single-byte holding register. An arriving byte overwrites it and sets the flag.

Top module: `dbg_uart_load_port`

## Requirements
- R1: After reset `rsp_valid` is 0 and the receive flag is clear, so an 8-byte read of the data address (0x7F000000) returns 0.
- R2: An 8-byte read of the data address returns the held byte in bits 31..24, the receive flag in bit 23, and zero in all other bits. A narrower read of N bytes keeps only the N least significant bytes of that word (bits 8N-1..0).
- R3: Reading the data address clears the receive flag. The held byte stays unchanged.
- R4: A read of the status address (0x7F000004) returns 0x000000000004FFFF truncated to the access size: 0xFF for 1 byte, 0xFFFF for 2 bytes, 0x04FFFF for 3 bytes.
- R5: A request to any other address raises `mem_req_valid` in the same cycle, with `mem_addr` equal to the request address and `mem_size` equal to the effective byte count. A request to either UART address never raises `mem_req_valid`.
- R6: For a memory read of N bytes, memory returns the byte at address A+i in `mem_rdata` bits 8i+7..8i, one cycle after the request. The response places that byte at bits 8(N-1-i)+7..8(N-1-i), and bits 63..8N are zero.
- R7: `rsp_valid` is 1 in exactly the cycle after a cycle in which `req_valid` is 1, and 0 otherwise.
- R8: A pulse on `rx_strobe` stores `rx_byte` and sets the flag. When a pulse and a read of the data address fall in the same cycle, the read returns the old contents and the flag is left set, holding the new byte.
- R9: A `req_size` of 0, or any value above 8, is treated as 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request present this cycle |
| req_addr | input | 64 | Load byte address |
| req_size | input | 4 | Access size in bytes (1 to 8) |
| rx_strobe | input | 1 | A received byte arrives this cycle |
| rx_byte | input | 8 | Received byte |
| mem_req_valid | output | 1 | Read request forwarded to memory |
| mem_addr | output | 64 | Forwarded address |
| mem_size | output | 4 | Forwarded effective byte count |
| mem_rdata | input | 64 | Memory read data, little-endian, one cycle after the request |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | 64 | Load data, big-endian, right-aligned |

## Verification
On every cycle the assertions check the following:
- the one-cycle response timing;
- that memory is requested for ordinary addresses and never for the two UART addresses;
- that a byte arrival sets the flag;
- that a data read with no arrival in the same cycle clears it;
- the full-width status constant;
- the zeroed upper bytes of a one-byte memory load.

Only the bench scenarios can show the rest:
- the exact byte placement after reversal at each size;
- truncation of the UART words;
- the old-value response when an arrival and a data read coincide;
- the clamping of out-of-range sizes.

// File: rtl/dbgu_pkg.sv
package dbgu_pkg;
   typedef enum logic {
      SRC_MEM   = 1'b0,
      SRC_LOCAL = 1'b1
   } rsp_src_e;

   localparam logic [63:0] DEF_DATA_ADDR = 64'h0000_0000_7F00_0000;
   localparam logic [63:0] DEF_STAT_ADDR = 64'h0000_0000_7F00_0004;
   localparam logic [63:0] DEF_STAT_WORD = 64'h0000_0000_0004_FFFF;
endpackage

// File: rtl/dbgu_rx_holder.sv
module dbgu_rx_holder #(
   parameter int RX_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arrive_i,
   input  logic [RX_W-1:0] arrive_byte_i,
   input  logic            consume_i,
   output logic [RX_W-1:0] byte_o,
   output logic            flag_o
);
   // Arrival has priority over a consuming read in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_o <= '0;
         flag_o <= 1'b0;
      end else if (arrive_i) begin
         byte_o <= arrive_byte_i;
         flag_o <= 1'b1;
      end else if (consume_i) begin
         flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/dbgu_size_decode.sv
module dbgu_size_decode #(
   parameter  int DATA_W = 64,
   parameter  int SIZE_W = 4,
   localparam int NB     = DATA_W / 8,
   localparam int CNT_W  = $clog2(NB + 1)
) (
   input  logic [SIZE_W-1:0] size_i,
   output logic [CNT_W-1:0]  nbytes_o,
   output logic [NB-1:0]     byte_en_o
);
   int req_n;

   always_comb begin
      req_n = int'(size_i);
      // Zero and oversize requests fall back to the full width.
      if (req_n < 1 || req_n > NB) nbytes_o = CNT_W'(NB);
      else                         nbytes_o = CNT_W'(req_n);
      for (int b = 0; b < NB; b++) begin
         byte_en_o[b] = (b < int'(nbytes_o));
      end
   end
endmodule

// File: rtl/dbgu_byte_order.sv
module dbgu_byte_order #(
   parameter  int DATA_W = 64,
   parameter  bit SWAP   = 1'b1,
   localparam int NB     = DATA_W / 8,
   localparam int CNT_W  = $clog2(NB + 1)
) (
   input  logic [DATA_W-1:0] in_i,
   input  logic [CNT_W-1:0]  nbytes_i,
   output logic [DATA_W-1:0] out_o
);
   generate
      if (SWAP) begin : g_swap
         // Byte i of an N-byte little-endian fetch lands at lane N-1-i.
         always_comb begin
            out_o = '0;
            for (int j = 0; j < NB; j++) begin
               for (int i = 0; i < NB; i++) begin
                  if (i + j + 1 == int'(nbytes_i)) out_o[8*j +: 8] = in_i[8*i +: 8];
               end
            end
         end
      end else begin : g_pass
         always_comb begin
            out_o = '0;
            for (int j = 0; j < NB; j++) begin
               if (j < int'(nbytes_i)) out_o[8*j +: 8] = in_i[8*j +: 8];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dbg_uart_load_port.sv
module dbg_uart_load_port
   import dbgu_pkg::*;
#(
   parameter  int              DATA_W    = 64,
   parameter  int              ADDR_W    = 64,
   parameter  int              SIZE_W    = 4,
   parameter  int              RX_W      = 8,
   parameter  int              RX_LSB    = 24,
   parameter  int              FLAG_BIT  = 23,
   parameter  logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DEF_DATA_ADDR),
   parameter  logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(DEF_STAT_ADDR),
   parameter  logic [DATA_W-1:0] STAT_WORD = DATA_W'(DEF_STAT_WORD),
   parameter  bit              BYTE_SWAP = 1'b1,
   localparam int              NB        = DATA_W / 8,
   localparam int              CNT_W     = $clog2(NB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              rx_strobe,
   input  logic [RX_W-1:0]   rx_byte,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CNT_W-1:0]  mem_size,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0) begin : g_chk_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (RX_LSB + RX_W > DATA_W) begin : g_chk_rx
      $error("received byte field exceeds the data width");
   end
   if (FLAG_BIT >= DATA_W || (FLAG_BIT >= RX_LSB && FLAG_BIT < RX_LSB + RX_W)) begin : g_chk_flag
      $error("flag bit out of range or overlapping the byte field");
   end
   if (DATA_ADDR == STAT_ADDR) begin : g_chk_addr
      $error("UART addresses must differ");
   end
   if ((2 ** SIZE_W) <= NB) begin : g_chk_size
      $error("SIZE_W too narrow for the byte count");
   end

   logic              hit_data, hit_stat, hit_local;
   logic [RX_W-1:0]   rx_byte_q;
   logic              rx_flag;
   logic [CNT_W-1:0]  req_nbytes;
   logic [NB-1:0]     req_byte_en;
   logic [DATA_W-1:0] bit_mask;
   logic [DATA_W-1:0] local_word;
   logic [DATA_W-1:0] ordered;

   logic              rsp_valid_q;
   rsp_src_e          src_q;
   logic [DATA_W-1:0] local_q;
   logic [CNT_W-1:0]  nbytes_q;

   assign hit_data  = (req_addr == DATA_ADDR);
   assign hit_stat  = (req_addr == STAT_ADDR);
   assign hit_local = hit_data | hit_stat;

   dbgu_size_decode #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_size (
      .size_i    (req_size),
      .nbytes_o  (req_nbytes),
      .byte_en_o (req_byte_en)
   );

   dbgu_rx_holder #(.RX_W(RX_W)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .arrive_i      (rx_strobe),
      .arrive_byte_i (rx_byte),
      .consume_i     (req_valid & hit_data),
      .byte_o        (rx_byte_q),
      .flag_o        (rx_flag)
   );

   // Forward non-UART loads to memory in the request cycle.
   assign mem_req_valid = req_valid & ~hit_local;
   assign mem_addr      = req_addr;
   assign mem_size      = req_nbytes;

   always_comb begin
      for (int b = 0; b < DATA_W; b++) bit_mask[b] = req_byte_en[b / 8];
   end

   always_comb begin
      local_word = '0;
      if (hit_data) begin
         local_word[RX_LSB +: RX_W] = rx_byte_q;
         local_word[FLAG_BIT]       = rx_flag;
      end else if (hit_stat) begin
         local_word = STAT_WORD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         src_q       <= SRC_MEM;
         local_q     <= '0;
         nbytes_q    <= '0;
      end else begin
         rsp_valid_q <= req_valid;
         if (req_valid) begin
            src_q    <= hit_local ? SRC_LOCAL : SRC_MEM;
            local_q  <= local_word & bit_mask;
            nbytes_q <= req_nbytes;
         end
      end
   end

   dbgu_byte_order #(.DATA_W(DATA_W), .SWAP(BYTE_SWAP)) u_order (
      .in_i     (mem_rdata),
      .nbytes_i (nbytes_q),
      .out_o    (ordered)
   );

   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = !rsp_valid_q       ? '0 :
                      (src_q == SRC_MEM) ? ordered : local_q;
endmodule

// File: rtl/dbgu_load_chk.sv
module dbgu_load_chk #(
   parameter int                DATA_W    = 64,
   parameter int                ADDR_W    = 64,
   parameter int                SIZE_W    = 4,
   parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
   parameter logic [ADDR_W-1:0] STAT_ADDR = '0,
   parameter logic [DATA_W-1:0] STAT_WORD = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [SIZE_W-1:0] req_size,
   input logic              rx_strobe,
   input logic              rx_flag_i,
   input logic              mem_req_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_data
);
   logic uart_hit;
   assign uart_hit = (req_addr == DATA_ADDR) || (req_addr == STAT_ADDR);

   // R7
   rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R7
   no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R5
   uart_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && uart_hit) |-> !mem_req_valid);
   // R5
   mem_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !uart_hit) |-> (mem_req_valid && mem_addr == req_addr));
   // R8
   arrival_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> rx_flag_i);
   // R3
   read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr == DATA_ADDR && !rx_strobe) |=> !rx_flag_i);
   // R4
   status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr == STAT_ADDR && req_size == SIZE_W'(8)) |=> (rsp_data == STAT_WORD));
   // R6
   one_byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !uart_hit && req_size == SIZE_W'(1)) |=> (rsp_data[DATA_W-1:8] == '0));
endmodule

bind dbg_uart_load_port dbgu_load_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .SIZE_W    (SIZE_W),
   .DATA_ADDR (DATA_ADDR),
   .STAT_ADDR (STAT_ADDR),
   .STAT_WORD (STAT_WORD)
) u_load_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_addr      (req_addr),
   .req_size      (req_size),
   .rx_strobe     (rx_strobe),
   .rx_flag_i     (rx_flag),
   .mem_req_valid (mem_req_valid),
   .mem_addr      (mem_addr),
   .rsp_valid     (rsp_valid),
   .rsp_data      (rsp_data)
);

// File: tb/tb_dbg_uart_load_port.sv
module tb_dbg_uart_load_port;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] DADDR = 64'h7F00_0000;
   localparam logic [63:0] SADDR = 64'h7F00_0004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic [3:0]  req_size = 4'd8;
   logic        rx_strobe = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        mem_req_valid;
   logic [63:0] mem_addr;
   logic [3:0]  mem_size;
   logic [63:0] mem_rdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_data;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_uart_load_port dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
      .mem_req_valid(mem_req_valid), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_byte(input logic [63:0] a);
      return a[7:0] * 8'd7 + 8'h13;
   endfunction

   function automatic int eff(input logic [3:0] s);
      return (s == 0 || s > 8) ? 8 : int'(s);
   endfunction

   // Little-endian memory image; lanes beyond the size hold junk.
   function automatic logic [63:0] mem_image(input logic [63:0] a, input int n);
      logic [63:0] d = 64'hEEEE_EEEE_EEEE_EEEE;
      for (int i = 0; i < n; i++) d[8*i +: 8] = mem_byte(a + 64'(i));
      return d;
   endfunction

   function automatic logic [63:0] be_value(input logic [63:0] a, input int n);
      logic [63:0] v = '0;
      for (int i = 0; i < n; i++) v[8*(n-1-i) +: 8] = mem_byte(a + 64'(i));
      return v;
   endfunction

   function automatic logic [63:0] trunc(input logic [63:0] w, input int n);
      logic [63:0] v = '0;
      for (int i = 0; i < 8*n; i++) v[i] = w[i];
      return v;
   endfunction

   // One load; optional byte arrival in the same cycle. Returns the response data.
   task automatic load(input logic [63:0] a, input logic [3:0] s, input bit with_rx,
                       input logic [7:0] b, input string tag, output logic [63:0] data);
      bit uart = (a == DADDR) || (a == SADDR);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = s;
      rx_strobe = with_rx; rx_byte = b;
      #1;
      check({tag, " R5 mem_req_valid"}, 64'(mem_req_valid), 64'(!uart));
      if (!uart) begin
         check({tag, " R5 mem_addr"}, mem_addr, a);
         check({tag, " R5/R9 mem_size"}, 64'(mem_size), 64'(eff(s)));
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0; rx_strobe = 1'b0;
      mem_rdata = uart ? 64'hDEAD_BEEF_DEAD_BEEF : mem_image(a, eff(s));
      @(negedge clk);
      check({tag, " R7 rsp_valid"}, 64'(rsp_valid), 64'd1);
      data = rsp_data;
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk);
      rx_strobe = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_strobe = 1'b0;
   endtask

   task automatic t_reset();
      logic [63:0] d;
      check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      load(DADDR, 4'd8, 1'b0, 8'h00, "reset", d);
      check("R1 data read after reset", d, 64'd0);
   endtask

   task automatic t_rx_read();
      logic [63:0] d;
      push_rx(8'hC3);
      load(DADDR, 4'd8, 1'b0, 8'h00, "rx", d);
      check("R2 R8 new byte with flag", d, 64'h0000_0000_C380_0000);
      load(DADDR, 4'd8, 1'b0, 8'h00, "rx", d);
      check("R3 flag cleared, byte kept", d, 64'h0000_0000_C300_0000);
   endtask

   task automatic t_trunc();
      logic [63:0] d;
      push_rx(8'h5E);
      load(DADDR, 4'd3, 1'b0, 8'h00, "trunc", d);
      check("R2 3-byte data read", d, 64'h0000_0000_0080_0000);
      load(DADDR, 4'd4, 1'b0, 8'h00, "trunc", d);
      check("R3 4-byte read after clear", d, 64'h0000_0000_5E00_0000);
      load(DADDR, 4'd2, 1'b0, 8'h00, "trunc", d);
      check("R2 2-byte data read", d, 64'd0);
   endtask

   task automatic t_status();
      logic [63:0] d;
      load(SADDR, 4'd1, 1'b0, 8'h00, "stat", d);
      check("R4 status 1 byte", d, 64'hFF);
      load(SADDR, 4'd2, 1'b0, 8'h00, "stat", d);
      check("R4 status 2 bytes", d, 64'hFFFF);
      load(SADDR, 4'd3, 1'b0, 8'h00, "stat", d);
      check("R4 status 3 bytes", d, 64'h04_FFFF);
      load(SADDR, 4'd8, 1'b0, 8'h00, "stat", d);
      check("R4 status 8 bytes", d, 64'h4_FFFF);
      load(SADDR, 4'd0, 1'b0, 8'h00, "stat", d);
      check("R9 status size 0 as 8", d, 64'h4_FFFF);
   endtask

   task automatic t_mem();
      logic [63:0] d;
      logic [63:0] addrs [5] = '{64'h1000, 64'h2003, 64'h7F00_0008, 64'h0, 64'hFFFF_FFFF_7F00_0000};
      logic [3:0]  sizes [5] = '{4'd1, 4'd2, 4'd4, 4'd8, 4'd9};
      for (int k = 0; k < 5; k++) begin
         load(addrs[k], sizes[k], 1'b0, 8'h00, "mem", d);
         check("R6 R9 memory byte reversal", d, be_value(addrs[k], eff(sizes[k])));
      end
      load(64'h3000, 4'd15, 1'b0, 8'h00, "mem", d);
      check("R9 size 15 as 8", d, be_value(64'h3000, 8));
   endtask

   task automatic t_race();
      logic [63:0] d;
      push_rx(8'h11);
      load(DADDR, 4'd8, 1'b1, 8'h22, "race", d);
      check("R8 read returns old contents", d, 64'h0000_0000_1180_0000);
      load(DADDR, 4'd8, 1'b0, 8'h00, "race", d);
      check("R8 arrival wins over clear", d, 64'h0000_0000_2280_0000);
   endtask

   task automatic t_overwrite();
      logic [63:0] d;
      push_rx(8'h33);
      push_rx(8'h44);
      load(DADDR, 4'd8, 1'b0, 8'h00, "ovr", d);
      check("R8 newest byte overwrites", d, 64'h0000_0000_4480_0000);
   endtask

   task automatic t_idle();
      @(negedge clk);
      @(negedge clk);
      check("R7 no response when idle", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rx_read();
      t_trunc();
      t_status();
      t_mem();
      t_race();
      t_overwrite();
      t_idle();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule